// File: doc/BRIEF.md
# Linear Parameter Sweep Engine

This block produces a 32-bit control word that moves in equal steps between a programmed start value and a programmed end value. The word can stand for a frequency, a phase or an amplitude. For a phase or amplitude word, only the top 14 or top 10 bits are significant. Software sets the block up through a small write-only register port. Once a sweep is running, a single direction input steers it. When the input is high, the word climbs toward the end value using the rising step size and the rising dwell time. When the input is low, the word descends toward the start value using the falling step size and the falling dwell time.

Step timing comes from a reloadable down counter that runs on the block clock. A no-dwell option turns a rising sweep into a repeating sawtooth: the word returns to the start value one interval after it reaches the end value. Step sizes and dwell times can be rewritten while a sweep is under way. This lets a piecewise or curved trajectory be built from straight segments.

Top module: `lin_sweep_engine`

## Requirements
- R1: Writes with `cfg_we` high land on the rising clock edge in the register selected by `cfg_addr`:
  - 0: start word
  - 1: end word
  - 2: rising step
  - 3: falling step
  - 4: dwell times, with bits [7:0] for rising and bits [15:8] for falling
  - 5: control, with bits [1:0] the parameter kind, bit 2 run, bit 3 no-dwell and bits [5:4] the level count
- R2: The parameter kind is encoded 00 none, 01 amplitude, 10 frequency, 11 phase. A sweep runs only when the kind is non-zero, the run bit is 1 and the level count is 00. Otherwise `param_kind` reads 00 and `sweep_word` reads the start word.
- R3: All values are read MSB-aligned:
  - A frequency sweep uses all 32 bits.
  - A phase sweep uses bits [31:18].
  - An amplitude sweep uses bits [31:22].
  - Lower bits of the start, end and step words are ignored and read as zero on `sweep_word`.
- R4: While `sweep_dir` is high, the word rises by the rising step once every N clocks, where N is the rising dwell time. The first step comes N clocks after the sweep starts.
- R5: While `sweep_dir` is low, the word falls by the falling step once every M clocks, where M is the falling dwell time.
- R6: A dwell time of 0 means 256 clocks between steps.
- R7: A rising sweep lands exactly on the end word and then holds. A falling sweep lands exactly on the start word and then holds. This applies even when the remaining distance is smaller than the step.
- R8: With no-dwell set, the step time that finds the word at the end word loads the start word instead of holding.
- R9: A change of `sweep_dir` restarts the interval timer with the new direction's dwell time. The current word is kept.
- R10: A step size written mid-sweep applies from the next step on, without restarting the interval timer.
- R11: After synchronous reset all registers are zero, `sweep_word` is 0 and `param_kind` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one tick is the unit of dwell time |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| sweep_dir | input | 1 | 1 sweeps toward the end word, 0 toward the start word |
| sweep_word | output | 32 | Current swept value, MSB-aligned |
| param_kind | output | 2 | Kind of parameter being driven, 00 when idle |

## Verification
The bench drives the last step of a sweep in both directions with a distance shorter than the step. A design that added or subtracted blindly would overshoot the bound or wrap around. It also tests a dwell time of zero, where a design with a plain 8-bit count would step every clock or never step at all. A direction flip mid-interval must keep the word and restart timing; a design that ran on the old count would step one clock early. Further cases cover a step size rewritten between steps, phase and amplitude writes with junk in the low bits (which a design without masking would leak into the output), and the no-dwell return that shows the end word for exactly one interval.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    parameter int WORD_W  = 32;
    parameter int PHASE_W = 14;
    parameter int AMP_W   = 10;
    parameter int RATE_W  = 8;
    parameter int ADDR_W  = 3;

    localparam int TIMER_W = RATE_W + 1;
    localparam logic [TIMER_W-1:0] RATE_MAX = TIMER_W'(1 << RATE_W);

    localparam logic [ADDR_W-1:0] REG_START  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] REG_END    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] REG_RISE_D = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] REG_FALL_D = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] REG_RATES  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] REG_CTRL   = ADDR_W'(5);

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_AMP   = 2'b01,
        KIND_FREQ  = 2'b10,
        KIND_PHASE = 2'b11
    } kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] start_w;
        logic [WORD_W-1:0] end_w;
        logic [WORD_W-1:0] rise_step;
        logic [WORD_W-1:0] fall_step;
        logic [RATE_W-1:0] rise_rate;
        logic [RATE_W-1:0] fall_rate;
        logic [1:0]        levels;
        logic              no_dwell;
        logic              run;
        kind_e             kind;
    } sweep_cfg_t;

    function automatic logic [WORD_W-1:0] kind_mask(kind_e k);
        logic [WORD_W-1:0] m;
        case (k)
            KIND_PHASE: m = {{PHASE_W{1'b1}}, {(WORD_W-PHASE_W){1'b0}}};
            KIND_AMP:   m = {{AMP_W{1'b1}},   {(WORD_W-AMP_W){1'b0}}};
            default:    m = {WORD_W{1'b1}};
        endcase
        return m;
    endfunction

    function automatic logic [TIMER_W-1:0] rate_count(logic [RATE_W-1:0] r);
        return (r == '0) ? RATE_MAX : {1'b0, r};
    endfunction

endpackage

// File: rtl/sweep_cfg_regs.sv
module sweep_cfg_regs
    import sweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output sweep_cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                REG_START:  cfg.start_w   <= wdata;
                REG_END:    cfg.end_w     <= wdata;
                REG_RISE_D: cfg.rise_step <= wdata;
                REG_FALL_D: cfg.fall_step <= wdata;
                REG_RATES: begin
                    cfg.rise_rate <= wdata[RATE_W-1:0];
                    cfg.fall_rate <= wdata[2*RATE_W-1:RATE_W];
                end
                REG_CTRL: begin
                    cfg.kind     <= kind_e'(wdata[1:0]);
                    cfg.run      <= wdata[2];
                    cfg.no_dwell <= wdata[3];
                    cfg.levels   <= wdata[5:4];
                end
                default: ;
            endcase
        end
    end

    // R1: a write to the control register is visible on the next cycle
    a_r1_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_CTRL) |=> (cfg.run == $past(wdata[2])));

endmodule

// File: rtl/sweep_interval_timer.sv
module sweep_interval_timer
    import sweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              dir,
    input  logic [RATE_W-1:0] rise_rate,
    input  logic [RATE_W-1:0] fall_rate,
    output logic              tick
);

    logic [TIMER_W-1:0] count;
    logic               dir_q;
    logic [TIMER_W-1:0] load_val;

    assign load_val = rate_count(dir ? rise_rate : fall_rate);
    assign tick     = active && (dir == dir_q) && (count == TIMER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= RATE_MAX;
            dir_q <= 1'b0;
        end else begin
            dir_q <= dir;
            if (!active || dir != dir_q || count == TIMER_W'(1))
                count <= load_val;
            else
                count <= count - TIMER_W'(1);
        end
    end

    // R6: the counter never sits at zero and never exceeds 256
    a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
        (count != '0) && (count <= RATE_MAX));

    // R9: a direction flip reloads the new direction's dwell time
    a_r9_dir_reload: assert property (@(posedge clk) disable iff (rst)
        (active && dir != dir_q) |=> (count == $past(load_val)));

endmodule

// File: rtl/sweep_step_calc.sv
module sweep_step_calc
    import sweep_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic [WORD_W-1:0] up_step,
    input  logic [WORD_W-1:0] down_step,
    input  logic              dir,
    input  logic              no_dwell,
    output logic [WORD_W-1:0] next
);

    logic [WORD_W-1:0] gap_up;
    logic [WORD_W-1:0] gap_down;

    assign gap_up   = hi - cur;
    assign gap_down = cur - lo;

    always_comb begin
        next = cur;
        if (dir) begin
            if (cur >= hi)
                next = (no_dwell && cur == hi) ? lo : cur;
            else if (gap_up <= up_step)
                next = hi;
            else
                next = cur + up_step;
        end else begin
            if (cur <= lo)
                next = cur;
            else if (gap_down <= down_step)
                next = lo;
            else
                next = cur - down_step;
        end
    end

endmodule

// File: rtl/lin_sweep_engine.sv
module lin_sweep_engine
    import sweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              sweep_dir,
    output logic [31:0]       sweep_word,
    output logic [1:0]        param_kind
);

    sweep_cfg_t        cfg;
    logic              active;
    logic              tick;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] start_m, end_m, rise_m, fall_m;
    logic [WORD_W-1:0] acc, acc_view, acc_next;

    sweep_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign active   = cfg.run && (cfg.kind != KIND_NONE) && (cfg.levels == 2'b00);
    assign mask     = kind_mask(cfg.kind);
    assign start_m  = cfg.start_w   & mask;
    assign end_m    = cfg.end_w     & mask;
    assign rise_m   = cfg.rise_step & mask;
    assign fall_m   = cfg.fall_step & mask;
    assign acc_view = acc & mask;

    sweep_interval_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .dir       (sweep_dir),
        .rise_rate (cfg.rise_rate),
        .fall_rate (cfg.fall_rate),
        .tick      (tick)
    );

    sweep_step_calc u_step (
        .cur       (acc_view),
        .lo        (start_m),
        .hi        (end_m),
        .up_step   (rise_m),
        .down_step (fall_m),
        .dir       (sweep_dir),
        .no_dwell  (cfg.no_dwell),
        .next      (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (!active)
            acc <= cfg.start_w;
        else if (tick)
            acc <= acc_next;
    end

    assign sweep_word = active ? acc_view : start_m;
    assign param_kind = active ? cfg.kind : KIND_NONE;

    // R2: while idle the accumulator is reloaded from the start word
    a_r2_idle_start: assert property (@(posedge clk) disable iff (rst)
        !active |=> (acc == $past(cfg.start_w)));

    // R4: between step times the word does not move
    a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
        (active && !tick && !cfg_we) |=> $stable(acc_view));

    // R7: a rising step never passes the end word
    a_r7_no_overshoot_up: assert property (@(posedge clk) disable iff (rst)
        (active && tick && sweep_dir && !cfg_we && acc_view <= end_m)
        |=> (acc_view <= $past(end_m) || acc_view == $past(start_m)));

    // R7: a falling step never passes the start word
    a_r7_no_overshoot_down: assert property (@(posedge clk) disable iff (rst)
        (active && tick && !sweep_dir && !cfg_we && acc_view >= start_m)
        |=> (acc_view >= $past(start_m)));

endmodule

// File: tb/lin_sweep_engine_test.sv
module lin_sweep_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        sweep_dir = 1'b0;
    logic [31:0] sweep_word;
    logic [1:0]  param_kind;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [31:0] word;
        logic [1:0]  kind;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_it;

    lin_sweep_engine uut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .sweep_dir  (sweep_dir),
        .sweep_word (sweep_word),
        .param_kind (param_kind)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items whose cycle has come
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            mon_it = sbq.pop_front();
            n_checks++;
            if (mon_it.at != cyc || sweep_word !== mon_it.word || param_kind !== mon_it.kind) begin
                n_fails++;
                $display("FAIL %s cycle %0d: word=%h kind=%b expected word=%h kind=%b",
                         mon_it.tag, cyc, sweep_word, param_kind, mon_it.word, mon_it.kind);
            end
        end
    end

    task automatic expect_in(input int k, input logic [31:0] w, input logic [1:0] kd, input string tag);
        exp_t e;
        e.at = cyc + k; e.word = w; e.kind = kd; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        expect_in(1, 32'h0, 2'b00, "R11 reset state");
        wait_cyc(2);

        // frequency sweep up: S0=100 E0=950 step 100 dwell 4
        wr(3'd0, 32'd100);
        wr(3'd1, 32'd950);
        wr(3'd2, 32'd100);
        wr(3'd3, 32'd50);
        wr(3'd4, 32'h0000_0304);
        sweep_dir = 1'b1;
        wait_cyc(2);
        wr(3'd5, 32'h6);
        expect_in(1,  32'd100, 2'b10, "R2 kind frequency");
        expect_in(3,  32'd100, 2'b10, "R4 before first step");
        expect_in(4,  32'd200, 2'b10, "R4 first step");
        expect_in(8,  32'd300, 2'b10, "R4 second step");
        expect_in(32, 32'd900, 2'b10, "R4 eighth step");
        expect_in(36, 32'd950, 2'b10, "R7 clamp at end");
        expect_in(40, 32'd950, 2'b10, "R7 hold at end");
        wait_cyc(40);

        // direction flip, falling sweep
        sweep_dir = 1'b0;
        expect_in(3, 32'd950, 2'b10, "R9 value kept after flip");
        expect_in(4, 32'd900, 2'b10, "R5 first fall step");
        expect_in(7, 32'd850, 2'b10, "R5 second fall step");
        wait_cyc(8);
        wr(3'd3, 32'd200);
        expect_in(1,  32'd650, 2'b10, "R10 new step applied");
        expect_in(4,  32'd450, 2'b10, "R10 new step again");
        expect_in(10, 32'd100, 2'b10, "R7 clamp at start");
        expect_in(14, 32'd100, 2'b10, "R7 hold at start");
        wait_cyc(14);

        // level count non-zero blocks the sweep
        wr(3'd5, 32'h16);
        expect_in(1, 32'd100, 2'b00, "R2 level count blocks");
        wait_cyc(2);

        // phase sweep with junk low bits, dwell 0 = 256
        wr(3'd0, 32'h1007_FFFF);
        wr(3'd1, 32'h2000_0000);
        wr(3'd2, 32'h0004_1234);
        wr(3'd4, 32'h0000_0300);
        sweep_dir = 1'b1;
        wait_cyc(2);
        wr(3'd5, 32'h7);
        expect_in(1,   32'h1004_0000, 2'b11, "R3 phase mask");
        expect_in(255, 32'h1004_0000, 2'b11, "R6 no step before 256");
        expect_in(256, 32'h1008_0000, 2'b11, "R6 step at 256");
        wait_cyc(257);

        // amplitude sawtooth with no-dwell
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h0040_0000);
        wr(3'd1, 32'h0100_0FFF);
        wr(3'd2, 32'h0040_0000);
        wr(3'd4, 32'h0000_0302);
        wr(3'd5, 32'hD);
        expect_in(1,  32'h0040_0000, 2'b01, "R3 amplitude start");
        expect_in(2,  32'h0080_0000, 2'b01, "R8 ramp step");
        expect_in(6,  32'h0100_0000, 2'b01, "R3 amplitude end masked");
        expect_in(7,  32'h0100_0000, 2'b01, "R8 end shown one interval");
        expect_in(8,  32'h0040_0000, 2'b01, "R8 return to start");
        expect_in(10, 32'h0080_0000, 2'b01, "R8 ramp repeats");
        wait_cyc(12);

        wr(3'd5, 32'h0);
        expect_in(1, 32'h0040_0000, 2'b00, "R2 run off shows start");
        wait_cyc(3);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL watchdog: run did not finish, expected completion");
                end
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule